// File: doc/BRIEF.md
# Security Coprocessor Byte-Port Mailbox

This block is the device end of a byte-wide host port made of two registers. It sits between a host bus with one address bit and a coprocessor core. The host reads and writes single bytes. Offset 0 is the data port. At offset 1, a read returns a status byte and a write delivers a command code.

A host transaction runs in a fixed order:
1. The host writes a start code to the command port.
2. It waits until the block shows it is ready for data.
3. It writes the payload one byte at a time. Before each byte, it waits for the input-full flag to drop.
4. It closes the request with an end code.

The block passes each payload byte to the core through a one-cycle strobe, then signals the end of the request. It then returns the response as a framed byte stream:
- a start marker with the frame flag raised,
- the core's bytes, each with output-full raised,
- a final end marker, again with the frame flag.

A cancel code written at any moment drops the frame in progress and makes the port ready for a new command.

Top module: `secport_mbx`

## Requirements
- R1: After reset the status byte reads 0x10 and the data port reads 0x00. Status bits are: [0] output full, [1] input full, [2] frame flag, [3] last write went to offset 1, [4] ready for command, [5] ready for data, [7:6] zero.
- R2: Writing 0x01 to the command port while ready for command sets bit 5 and clears bit 4 from the next cycle.
- R3: A data-port write inside a frame sets bit 1 on the next cycle. In that same cycle, devCmdValid presents the byte. Bit 1 is clear again one cycle later.
- R4: A data-port write while not in the data phase of a frame is ignored. Bit 1 stays clear and no byte reaches the core.
- R5: Bit 3 is 1 when the most recent host write went to offset 1 and 0 when it went to offset 0.
- R6: Writing 0x03 during the data phase pulses devCmdEnd. It also presents the start marker 0x01 on the data port with bits 0 and 2 set.
- R7: A data-port read clears bits 0 and 2. Each response byte is then taken from the core through rspValid/rspReady and shown with bit 0 set and bit 2 clear.
- R8: After the host reads the byte marked rspLast, the block shows 0x03 with bits 0 and 2 set. Reading that marker returns the port to ready for command.
- R9: Writing 0x22 to the command port in any state clears bits 0, 1, 2 and 5, sets bit 4 and pulses devAbort on the next cycle. The abandoned response is never shown.
- R10: A command code that does not fit the current state changes nothing except bit 3. This covers 0x01 outside the idle state, 0x03 outside the data phase, and any unknown code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 1 | Register select: 0 data, 1 status/command |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | DW | Host write byte |
| hostRdata | output | DW | Host read byte (status or data register) |
| devCmdValid | output | 1 | One-cycle strobe: request byte to the core |
| devCmdByte | output | DW | Request byte |
| devCmdEnd | output | 1 | One-cycle strobe: request complete |
| devAbort | output | 1 | One-cycle strobe: frame cancelled |
| rspValid | input | 1 | Core offers a response byte |
| rspByte | input | DW | Response byte |
| rspLast | input | 1 | Offered byte is the final one |
| rspReady | output | 1 | Block takes the offered byte this cycle |

## Verification
The hardest cases to reach are cancels that land in the middle of a frame. One lands during the payload phase. The other lands after the start marker of a response has been read, while the core is still offering echo bytes. Directed sequences drive the port into each of these states through the normal host protocol and then write the cancel code. They check that the abandoned response never appears and that the next transaction starts clean. Random frames of random length then run back to back, each one opening with a cancel.

// File: rtl/secport_pkg.sv
`timescale 1ns/1ps
package secport_pkg;
  localparam logic [7:0] CODE_START  = 8'h01;
  localparam logic [7:0] CODE_END    = 8'h03;
  localparam logic [7:0] CODE_CANCEL = 8'h22;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2
  } portState_e;

  typedef struct packed {
    logic loadIn;
    logic loadStart;
    logic loadEnd;
    logic loadRsp;
  } portStrobe_t;
endpackage

// File: rtl/secport_ctrl.sv
`timescale 1ns/1ps
module secport_ctrl
  import secport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostAddr,
  input  logic          hostRd,
  input  logic          hostWr,
  input  logic [DW-1:0] hostWdata,
  input  logic          rspValid,
  input  logic          rspLast,
  output portStrobe_t   strb,
  output logic          obf,
  output logic          ibf,
  output logic          f0,
  output logic          a2,
  output logic          rdy,
  output logic          ibr,
  output logic          rspReady,
  output logic          cmdEnd,
  output logic          abort
);
  portState_e state;
  logic endPend, endShown;
  logic wrCmd, wrData, rdData, isCancel, isStart, isEnd, acceptData, rspFire;

  assign wrCmd      = hostWr & hostAddr;
  assign wrData     = hostWr & ~hostAddr;
  assign rdData     = hostRd & ~hostAddr;
  assign isCancel   = wrCmd && (hostWdata == DW'(CODE_CANCEL));
  assign isStart    = wrCmd && (hostWdata == DW'(CODE_START));
  assign isEnd      = wrCmd && (hostWdata == DW'(CODE_END));
  assign acceptData = wrData && (state == ST_RX);
  assign rspReady   = (state == ST_TX) && !obf && !endPend && !endShown;
  assign rspFire    = rspReady && rspValid;
  assign rdy        = (state == ST_IDLE);
  assign ibr        = (state == ST_RX);

  always_comb begin
    strb.loadIn    = acceptData;
    strb.loadStart = (state == ST_RX) && isEnd;
    strb.loadEnd   = (state == ST_TX) && !obf && endPend;
    strb.loadRsp   = rspFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      f0       <= 1'b0;
      a2       <= 1'b0;
      endPend  <= 1'b0;
      endShown <= 1'b0;
      cmdEnd   <= 1'b0;
      abort    <= 1'b0;
    end else begin
      cmdEnd <= 1'b0;
      abort  <= 1'b0;
      if (hostWr) a2 <= hostAddr;
      if (isCancel) begin
        state    <= ST_IDLE;
        ibf      <= 1'b0;
        obf      <= 1'b0;
        f0       <= 1'b0;
        endPend  <= 1'b0;
        endShown <= 1'b0;
        abort    <= 1'b1;
      end else begin
        ibf <= acceptData;
        case (state)
          ST_IDLE: if (isStart) state <= ST_RX;
          ST_RX: if (isEnd) begin
            state  <= ST_TX;
            obf    <= 1'b1;
            f0     <= 1'b1;
            cmdEnd <= 1'b1;
          end
          ST_TX: begin
            if (rdData && obf) begin
              obf <= 1'b0;
              f0  <= 1'b0;
              if (endShown) begin
                state    <= ST_IDLE;
                endShown <= 1'b0;
              end
            end else if (!obf && endPend) begin
              obf      <= 1'b1;
              f0       <= 1'b1;
              endPend  <= 1'b0;
              endShown <= 1'b1;
            end else if (rspFire) begin
              obf     <= 1'b1;
              endPend <= rspLast;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  ibf_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ibf && !hostWr |=> !ibf);

  // R4
  stray_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrData && !ibr |=> !ibf);

  // R9
  cancel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCancel |=> rdy && !ibr && !obf && !ibf && !f0 && abort);

  // R2
  start_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    isStart && rdy |=> ibr && !rdy);
endmodule

// File: rtl/secport_dpath.sv
`timescale 1ns/1ps
module secport_dpath
  import secport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  portStrobe_t   strb,
  input  logic          hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic [DW-1:0] rspByte,
  input  logic          obf,
  input  logic          ibf,
  input  logic          f0,
  input  logic          a2,
  input  logic          rdy,
  input  logic          ibr,
  output logic [DW-1:0] hostRdata,
  output logic [DW-1:0] cmdByte,
  output logic [DW-1:0] outByte
);
  localparam int FLAG_N = 6;
  logic [DW-1:0] inReg, outReg, statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg  <= '0;
      outReg <= '0;
    end else begin
      if (strb.loadIn) inReg <= hostWdata;
      if (strb.loadStart)    outReg <= DW'(CODE_START);
      else if (strb.loadEnd) outReg <= DW'(CODE_END);
      else if (strb.loadRsp) outReg <= rspByte;
    end
  end

  assign statusByte = {{(DW-FLAG_N){1'b0}}, ibr, rdy, a2, f0, ibf, obf};
  assign hostRdata  = hostAddr ? statusByte : outReg;
  assign cmdByte    = inReg;
  assign outByte    = outReg;
endmodule

// File: rtl/secport_mbx.sv
`timescale 1ns/1ps
module secport_mbx
  import secport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostAddr,
  input  logic          hostRd,
  input  logic          hostWr,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  output logic          devCmdValid,
  output logic [DW-1:0] devCmdByte,
  output logic          devCmdEnd,
  output logic          devAbort,
  input  logic          rspValid,
  input  logic [DW-1:0] rspByte,
  input  logic          rspLast,
  output logic          rspReady
);
  portStrobe_t strb;
  logic obf, ibf, f0, a2, rdy, ibr;
  logic [DW-1:0] outByte;

  secport_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd),
    .hostWr(hostWr), .hostWdata(hostWdata), .rspValid(rspValid),
    .rspLast(rspLast), .strb(strb), .obf(obf), .ibf(ibf), .f0(f0),
    .a2(a2), .rdy(rdy), .ibr(ibr), .rspReady(rspReady),
    .cmdEnd(devCmdEnd), .abort(devAbort)
  );

  secport_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .rspByte(rspByte), .obf(obf), .ibf(ibf),
    .f0(f0), .a2(a2), .rdy(rdy), .ibr(ibr), .hostRdata(hostRdata),
    .cmdByte(devCmdByte), .outByte(outByte)
  );

  assign devCmdValid = ibf;

  // R6
  start_marker_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && hostAddr && hostWdata == DW'(CODE_END) && ibr
    |=> f0 && obf && devCmdEnd && outByte == DW'(CODE_START));
endmodule

// File: tb/secport_mbx_tb.sv
`timescale 1ns/1ps
module secport_mbx_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostAddr = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata, devCmdByte;
  logic devCmdValid, devCmdEnd, devAbort, rspReady;
  logic rspValid = 1'b0, rspLast = 1'b0;
  logic [7:0] rspByte = 8'h00;

  int total = 0, bad = 0, cyc = 0;
  int capN = 0, endCnt = 0, abortCnt = 0;
  int respN = 0, respIdx = 0;
  bit respOn = 0, hsPend = 0;
  logic [7:0] capb [16];
  logic [7:0] txb [16];

  always #2.5 clk = ~clk;

  secport_mbx #(.DW(8)) u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd),
    .hostWr(hostWr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .devCmdValid(devCmdValid), .devCmdByte(devCmdByte),
    .devCmdEnd(devCmdEnd), .devAbort(devAbort), .rspValid(rspValid),
    .rspByte(rspByte), .rspLast(rspLast), .rspReady(rspReady)
  );

  // Device-side monitor and echo responder
  always @(negedge clk) begin
    if (devCmdValid && capN < 16) begin capb[capN] = devCmdByte; capN++; end
    if (devCmdEnd) begin endCnt++; respN = capN; respIdx = 0; respOn = 1; end
    if (devAbort) begin abortCnt++; respOn = 0; end
    if (hsPend) respIdx++;
    rspValid = respOn && (respIdx < respN);
    rspByte  = capb[respIdx % 16];
    rspLast  = (respIdx == respN - 1);
    hsPend   = rspValid && rspReady;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    hostAddr = a; #1; d = hostRdata; hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  function automatic logic [7:0] statusOf(bit ibr, bit rdy, bit a2, bit f0, bit ibf, bit obf);
    return {2'b00, ibr, rdy, a2, f0, ibf, obf};
  endfunction

  task automatic doTxn(input int n);
    logic [7:0] s, d;
    int k, tries, endBefore;
    wr(1'b1, 8'h22);
    rd(1'b1, s); check(s == statusOf(0,1,1,0,0,0), "R9 cancel status", s, statusOf(0,1,1,0,0,0));
    capN = 0;
    wr(1'b1, 8'h01);
    rd(1'b1, s); check(s == statusOf(1,0,1,0,0,0), "R2 data phase", s, statusOf(1,0,1,0,0,0));
    for (int i = 0; i < n; i++) begin
      wr(1'b0, txb[i]);
      rd(1'b1, s); check(s == statusOf(1,0,0,0,1,0), "R3/R5 ibf set", s, statusOf(1,0,0,0,1,0));
      rd(1'b1, s); check(s == statusOf(1,0,0,0,0,0), "R3 ibf clear", s, statusOf(1,0,0,0,0,0));
    end
    endBefore = endCnt;
    wr(1'b1, 8'h03);
    rd(1'b1, s); check(s == statusOf(0,0,1,1,0,1), "R6 start flags", s, statusOf(0,0,1,1,0,1));
    check(endCnt == endBefore + 1, "R6 end pulse", endCnt, endBefore + 1);
    check(capN == n, "R3 byte count", capN, n);
    for (int i = 0; i < n; i++)
      check(capb[i] == txb[i], "R3 byte value", capb[i], txb[i]);
    rd(1'b0, d); check(d == 8'h01, "R6 start marker", d, 8'h01);
    k = 0;
    forever begin
      tries = 0;
      rd(1'b1, s);
      while (!s[0] && tries < 50) begin rd(1'b1, s); tries++; end
      if (s[2] || !s[0] || k >= 16) break;
      check(s == statusOf(0,0,1,0,0,1), "R7 byte flags", s, statusOf(0,0,1,0,0,1));
      rd(1'b0, d); check(d == txb[k], "R7 echo byte", d, txb[k]);
      k++;
    end
    check(k == n, "R8 byte total", k, n);
    check(s == statusOf(0,0,1,1,0,1), "R8 end flags", s, statusOf(0,0,1,1,0,1));
    rd(1'b0, d); check(d == 8'h03, "R8 end marker", d, 8'h03);
    rd(1'b1, s); check(s == statusOf(0,1,1,0,0,0), "R8 back to ready", s, statusOf(0,1,1,0,0,0));
  endtask

  initial begin
    logic [7:0] s, d;
    int ab, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    rd(1'b1, s); check(s == 8'h10, "R1 reset status", s, 8'h10);
    rd(1'b0, d); check(d == 8'h00, "R1 reset data", d, 8'h00);

    wr(1'b0, 8'h55);
    rd(1'b1, s); check(s == 8'h10, "R4/R5 idle data write", s, 8'h10);
    check(capN == 0, "R4 no byte to core", capN, 0);
    wr(1'b1, 8'h03);
    rd(1'b1, s); check(s == 8'h18, "R10 end in idle", s, 8'h18);
    check(endCnt == 0, "R10 no end pulse", endCnt, 0);
    wr(1'b1, 8'h77);
    rd(1'b1, s); check(s == 8'h18, "R10 unknown code", s, 8'h18);

    txb[0] = 8'hA5; txb[1] = 8'h00; txb[2] = 8'hFF;
    doTxn(3);

    // R10: start while already in data phase
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h01);
    rd(1'b1, s); check(s == 8'h28, "R10 start in frame", s, 8'h28);

    // R9: cancel during data phase
    capN = 0;
    wr(1'b0, 8'hAA);
    ab = abortCnt;
    wr(1'b1, 8'h22);
    rd(1'b1, s); check(s == 8'h18, "R9 cancel in rx", s, 8'h18);
    check(abortCnt == ab + 1, "R9 abort pulse", abortCnt, ab + 1);
    wr(1'b0, 8'h66);
    rd(1'b1, s); check(s == 8'h10, "R4 write after cancel", s, 8'h10);
    check(capN == 1, "R4 no extra byte", capN, 1);

    // R9: cancel after start marker read, response pending
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h3C);
    wr(1'b0, 8'hC3);
    wr(1'b1, 8'h03);
    rd(1'b1, s);
    rd(1'b0, d); check(d == 8'h01, "R6 marker before cancel", d, 8'h01);
    wr(1'b1, 8'h22);
    repeat (6) @(negedge clk);
    rd(1'b1, s); check(s == 8'h18, "R9 cancel in tx", s, 8'h18);

    for (int t = 0; t < 12; t++) begin
      n = 1 + ($urandom % 8);
      for (int i = 0; i < n; i++) txb[i] = 8'($urandom);
      doTxn(n);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule